// File: doc/BRIEF.md
# Byte Table Translation Engine

The engine rewrites a run of bytes in memory, in place, by passing each one through a 256-entry substitution table that lives in the same memory. A request gives three values: the address of the first data byte, a byte count and the base address of the table. The value of each data byte is used as the offset into the table. The table byte at that offset is written back over the data byte. For example, this can turn one 8-bit character code into another.

The engine owns one port of a single-port, byte-wide synchronous memory. A read issued in one cycle returns its data in the next cycle. Each byte takes three memory cycles: read the data byte, read the table entry, write the result. A one-cycle `start` launches a job. `busy` stays high while the job runs. `done` pulses when the job finishes. The controller has four states:
- ST_IDLE: waiting for a request.
- ST_FETCH: reading the data byte.
- ST_LOOKUP: reading the table entry.
- ST_STORE: writing the translated byte.

The transitions are:
- ST_IDLE to ST_FETCH on `start` with a nonzero count.
- ST_FETCH to ST_LOOKUP always.
- ST_LOOKUP to ST_STORE always.
- ST_STORE to ST_FETCH while bytes remain.
- ST_STORE to ST_IDLE after the last byte.
- ST_IDLE stays in ST_IDLE (with a `done` pulse) on `start` with a zero count.

Top module: `xlat_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_en` and `mem_we` are all low.
- R2: Each data byte of value v is replaced by the table byte at offset v. With table base 0x1000 holding 0x30..0x39 at offsets 0xF0..0xF9, the data bytes F1 F9 F8 F4 become 31 39 38 34.
- R3: Exactly `length` consecutive bytes are processed, starting at `data_base` and going upward. The bytes just before and just after that run are left unchanged.
- R4: Each byte uses three consecutive memory cycles in a fixed order. First a read of the data byte, then a read of the table entry, then a write (`mem_we`=1) to the data byte's address. No other memory cycles occur, so a job of L bytes performs 3L accesses.
- R5: The table entry address is `table_base` plus the byte value, taken modulo 2^16. For example, base 0xFF80 with value 0x90 gives address 0x0010.
- R6: A request with `length` of zero causes no memory access. `done` pulses in the cycle after `start`, and `busy` stays low.
- R7: `done` is high for exactly one cycle, in the cycle after the last write, and `busy` is low from that cycle on. The full job, counted from the `start` cycle to the `done` cycle, spans 3L+1 cycles.
- R8: While `busy` is high, `start` is ignored. Changing `start` or the request operands during a job does not change the job's result, its length or the memory outside its run.
- R9: A `start` accepted in idle with a nonzero length raises `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled only when idle |
| data_base | input | 16 | Address of first data byte |
| length | input | 16 | Number of bytes to translate |
| table_base | input | 16 | Base address of the 256-entry table |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read |

## Verification
The following are checked on every cycle:
- Each write lands on the address read two cycles earlier.
- `done` never lasts more than one cycle and always accompanies the fall of `busy`.
- A zero-length request finishes without raising `busy`.
- The stored pointer and count hold still unless the engine loads or steps them.

Only the bench scenarios can show the rest. These are the translated values themselves, the untouched bytes around each run, the table address wrapping past 0xFFFF, the total job duration, and that a mid-job request leaves no trace.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOOKUP,
        ST_STORE
    } xlat_state_e;
endpackage

// File: rtl/xlat_walker.sv
// Holds the running data pointer, the remaining count and the table base.
module xlat_walker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] data_base,
    input  logic [ADDR_W-1:0] length,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] lookup_addr,
    output logic              last
);
    localparam int PAD_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] remain_q;
    logic [ADDR_W-1:0] tbase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
            tbase_q  <= '0;
        end else if (load) begin
            cur_addr <= data_base;
            remain_q <= length;
            tbase_q  <= table_base;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            remain_q <= remain_q - ADDR_W'(1);
        end
    end

    // Sum truncated to ADDR_W bits: wraps around the address space (R5)
    assign lookup_addr = tbase_q + {{PAD_W{1'b0}}, rd_byte};
    assign last        = (remain_q == ADDR_W'(1));

    // R8: without load or step the job context must not move
    a_r8_context_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cur_addr) && $stable(remain_q) && $stable(tbase_q)));

    // R3: every step advances to the next consecutive byte
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));
endmodule

// File: rtl/xlat_ctrl.sv
// Sequencer: read data, read table entry, write result, per byte.
module xlat_ctrl
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_empty,
    input  logic        last,
    output logic        load,
    output logic        step,
    output logic        sel_table,
    output logic        busy,
    output logic        done,
    output logic        mem_en,
    output logic        mem_we
);
    xlat_state_e state_q, state_d;
    logic        done_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && !req_empty) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_STORE;
            ST_STORE:  state_d = last ? ST_IDLE : ST_FETCH;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
        end
    end

    always_comb begin
        load      = 1'b0;
        step      = 1'b0;
        sel_table = 1'b0;
        mem_en    = 1'b1;
        mem_we    = 1'b0;
        busy      = 1'b1;
        done_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                mem_en = 1'b0;
                load   = start && !req_empty;
                done_d = start && req_empty;
            end
            ST_FETCH:  ;
            ST_LOOKUP: sel_table = 1'b1;
            ST_STORE: begin
                mem_we = 1'b1;
                step   = 1'b1;
                done_d = last;
            end
            default: begin
                busy   = 1'b0;
                mem_en = 1'b0;
            end
        endcase
    end

    // R7: the completion pulse lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: leaving the busy phase is always announced by done
    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: a new job is never loaded while one runs
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$past(load));
endmodule

// File: rtl/xlat_engine.sv
module xlat_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] data_base,
    input  logic [ADDR_W-1:0] length,
    input  logic [ADDR_W-1:0] table_base,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              load, step, sel_table, last;
    logic [ADDR_W-1:0] cur_addr, lookup_addr;
    logic              req_empty;

    assign req_empty = (length == '0);

    xlat_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_empty (req_empty),
        .last      (last),
        .load      (load),
        .step      (step),
        .sel_table (sel_table),
        .busy      (busy),
        .done      (done),
        .mem_en    (mem_en),
        .mem_we    (mem_we)
    );

    xlat_walker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .data_base   (data_base),
        .length      (length),
        .table_base  (table_base),
        .rd_byte     (mem_rdata),
        .cur_addr    (cur_addr),
        .lookup_addr (lookup_addr),
        .last        (last)
    );

    assign mem_addr  = sel_table ? lookup_addr : cur_addr;
    // In the store cycle the read port returns the table entry
    assign mem_wdata = mem_rdata;

    // R4: the write goes back to the address read two cycles before
    a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr, 2)));

    // R4: a write is always preceded by two reads
    a_r4_two_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_en) && !$past(mem_we) && $past(mem_en, 2) && !$past(mem_we, 2)));

    // R6: an empty request completes at once without going busy
    a_r6_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && length == '0) |=> (done && !busy && !mem_en));

    // R9: a nonempty request starts the job in the next cycle
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && length != '0) |=> (busy && mem_en && !mem_we));
endmodule

// File: tb/test_xlat_engine.sv
`timescale 1ns/1ps
module test_xlat_engine;
    localparam int AW = 16;
    localparam int DW = 8;

    typedef struct packed {
        logic [15:0] da;
        logic [15:0] len;
        logic [15:0] tb;
        logic [7:0]  mul;
        logic [7:0]  add;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{16'h0200, 16'd1,  16'h4000, 8'd3, 8'h11},
        '{16'h0300, 16'd16, 16'h5000, 8'd5, 8'h20},
        '{16'h1234, 16'd37, 16'h6000, 8'd1, 8'h80},
        '{16'h0400, 16'd8,  16'hFF80, 8'd7, 8'h01}   // table wraps past 0xFFFF (R5)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] data_base = '0, length = '0, table_base = '0;
    logic          busy, done, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xlat_engine i_xlat_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .data_base  (data_base),
        .length     (length),
        .table_base (table_base),
        .busy       (busy),
        .done       (done),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    // Sparse memory model, one-cycle synchronous read
    logic [7:0] mem [logic [15:0]];

    function automatic logic [7:0] rdm(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Access monitor: order of accesses and addresses per triple (R4, R5)
    int          acc_n = 0;
    int          bad_order = 0;
    logic [15:0] trip_addr = '0;
    logic [15:0] exp_tb = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (((acc_n % 3) == 2) != mem_we) bad_order++;
            if ((acc_n % 3) == 0) trip_addr = mem_addr;
            if ((acc_n % 3) == 1 && mem_addr != 16'(exp_tb + {8'h00, mem_rdata})) bad_order++;
            if ((acc_n % 3) == 2 && mem_addr != trip_addr) bad_order++;
            acc_n++;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata <= rdm(mem_addr);
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Launch a job; optionally poke start with other operands mid-job (R8).
    task automatic run_job(input logic [15:0] da, input logic [15:0] len,
                           input logic [15:0] tb, input bit poke, output int cycles);
        @(negedge clk);
        acc_n = 0;
        bad_order = 0;
        exp_tb = tb;
        data_base = da; length = len; table_base = tb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done) begin
            if (poke && cycles == 2) begin
                start = 1'b1; data_base = 16'h0800; length = 16'd5; table_base = 16'h2000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
            if (cycles > 2000) begin
                check(1'b0, "watchdog", cycles, 0);
                finish_run();
            end
        end
        start = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cyc;
        logic [7:0] exp_b [];

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_en && !mem_we, "R1 idle after reset",
              {busy, done, mem_en, mem_we}, 0);

        // Vector table walk: R2, R3, R4, R5, R7
        for (int n = 0; n < NV; n++) begin
            vec_t v = VECS[n];
            mem.delete();
            for (int t = 0; t < 256; t++)
                mem[16'(v.tb + 16'(t))] = 8'(t * int'(v.mul) + int'(v.add));
            exp_b = new[v.len];
            for (int i = 0; i < int'(v.len); i++) begin
                logic [7:0] b = 8'(i * 37 + 8'h90 + n);
                mem[16'(v.da + 16'(i))] = b;
                exp_b[i] = 8'(int'(b) * int'(v.mul) + int'(v.add));
            end
            mem[16'(v.da - 1)] = 8'hA5;
            mem[16'(v.da + v.len)] = 8'h5A;
            run_job(v.da, v.len, v.tb, 1'b0, cyc);
            check(cyc == 3 * int'(v.len) + 1, "R7 job duration", cyc, 3 * int'(v.len) + 1);
            check(acc_n == 3 * int'(v.len), "R4 access count", acc_n, 3 * int'(v.len));
            check(bad_order == 0, "R4/R5 access order and table address", bad_order, 0);
            for (int i = 0; i < int'(v.len); i++)
                check(rdm(16'(v.da + 16'(i))) == exp_b[i], "R2 translated byte",
                      rdm(16'(v.da + 16'(i))), exp_b[i]);
            check(rdm(16'(v.da - 1)) == 8'hA5, "R3 byte before run", rdm(16'(v.da - 1)), 8'hA5);
            check(rdm(16'(v.da + v.len)) == 8'h5A, "R3 byte after run",
                  rdm(16'(v.da + v.len)), 8'h5A);
            @(negedge clk);
            check(!done && !busy, "R7 done is a single pulse", {done, busy}, 0);
        end

        // R2: worked example, digits through a code table at 0x1000
        mem.delete();
        for (int d = 0; d < 10; d++) mem[16'h10F0 + 16'(d)] = 8'h30 + 8'(d);
        mem[16'h2100] = 8'hF1; mem[16'h2101] = 8'hF9;
        mem[16'h2102] = 8'hF8; mem[16'h2103] = 8'hF4;
        run_job(16'h2100, 16'd4, 16'h1000, 1'b0, cyc);
        check({rdm(16'h2100), rdm(16'h2101), rdm(16'h2102), rdm(16'h2103)} == 32'h31393834,
              "R2 example result",
              {rdm(16'h2100), rdm(16'h2101), rdm(16'h2102), rdm(16'h2103)}, 32'h31393834);

        // R5: single byte, table address wraps to 0x0010
        mem.delete();
        mem[16'h0010] = 8'h77;
        mem[16'h0900] = 8'h90;
        run_job(16'h0900, 16'd1, 16'hFF80, 1'b0, cyc);
        check(rdm(16'h0900) == 8'h77, "R5 wrapped table lookup", rdm(16'h0900), 8'h77);

        // R6: zero length
        mem.delete();
        mem[16'h0A00] = 8'h42;
        run_job(16'h0A00, 16'd0, 16'h1000, 1'b0, cyc);
        check(cyc == 1, "R6 zero-length done timing", cyc, 1);
        check(acc_n == 0, "R6 zero-length memory accesses", acc_n, 0);
        check(rdm(16'h0A00) == 8'h42, "R6 zero-length data untouched", rdm(16'h0A00), 8'h42);

        // R8: start with other operands while busy is ignored
        mem.delete();
        for (int t = 0; t < 256; t++) mem[16'h1000 + 16'(t)] = 8'(t + 1);
        for (int t = 0; t < 256; t++) mem[16'h2000 + 16'(t)] = 8'(t ^ 8'hFF);
        for (int i = 0; i < 3; i++) mem[16'h0700 + 16'(i)] = 8'(i + 8'h40);
        for (int i = 0; i < 5; i++) mem[16'h0800 + 16'(i)] = 8'(i + 8'h60);
        run_job(16'h0700, 16'd3, 16'h1000, 1'b1, cyc);
        check(cyc == 10, "R8 job length unchanged by mid-job start", cyc, 10);
        for (int i = 0; i < 3; i++)
            check(rdm(16'h0700 + 16'(i)) == 8'(i + 8'h41), "R8 original job result",
                  rdm(16'h0700 + 16'(i)), i + 8'h41);
        for (int i = 0; i < 5; i++)
            check(rdm(16'h0800 + 16'(i)) == 8'(i + 8'h60), "R8 ignored request left no trace",
                  rdm(16'h0800 + 16'(i)), i + 8'h60);
        repeat (3) @(negedge clk);
        check(!busy, "R8 no second job launched", busy, 0);

        // R9: busy rises the cycle after an accepted start
        @(negedge clk);
        data_base = 16'h0700; length = 16'd2; table_base = 16'h1000; start = 1'b1;
        check(!busy, "R9 idle before start", busy, 0);
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 busy after start", busy, 1);
        while (!done) @(negedge clk);

        finish_run();
    end
endmodule